// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block produces the status byte that a flash read returns while an internal program or erase is running, has failed, or is suspended. A timing engine elsewhere tells it when an operation starts, which kind it is, whether it is still busy, whether its pulse budget ran out and whether the erase-collect window has closed. The block tracks the polling state and, for every read strobe, either returns a status byte or tells the read path to return array data instead.

Host drivers decide when an operation finishes from this byte. They watch bit 7 against the intended data, or they watch bit 6 change from one read to the next. The block follows those rules cycle by cycle, so that polling software can be tested against it. An attempt to program a write-protected location looks busy for a fixed number of cycles and then falls back to array reads.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, `use_array` is 1, and the toggle bit and the failure flag are both clear.
- R2: `op_start` captures `op_kind` (2'b01 program, 2'b10 chip erase, 2'b11 sector erase) and `prog_bit7`. While a program is in status mode, bit 7 of `status_q` is the inverse of the captured bit.
- R3: While an erase is in status mode and not suspended, bit 7 of `status_q` reads 0.
- R4: Bit 6 of `status_q` is the toggle flop. `op_start` clears it on the next edge. Otherwise it inverts on every clock where `rd_stb` is high, the block is in status mode and no suspend is in effect. In all other cases it holds.
- R5: Bit 5 sets on the edge after `limit_hit` is seen while an operation is active. It stays set until the edge after `reset_cmd`. While it is set, the block stays in status mode even after `op_busy` falls.
- R6: Bit 3 equals `window_done` during an erase and reads 0 during a program.
- R7: When `suspended` is high during a sector erase, a read whose `rd_sector` bit is set in `erase_mask` returns status with bit 7 = 1, and bit 6 does not change. A read of a sector that is not in the mask gets `use_array` = 1. During a chip erase, `suspended` has no effect.
- R8: An `op_start` for a program with `tgt_locked` high holds the block in status mode for exactly PROT_CYCLES cycles, even with `op_busy` low. After that, `use_array` returns to 1.
- R9: Bits 4, 2, 1 and 0 of `status_q` always read 0. `use_array` is 1 whenever no operation is active and bit 5 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | One-cycle pulse at the start of an operation |
| op_kind | input | 2 | Operation kind, captured at op_start |
| prog_bit7 | input | 1 | Bit 7 of the byte being programmed |
| tgt_locked | input | 1 | The program target is write-protected |
| op_busy | input | 1 | The timing engine is running the operation |
| limit_hit | input | 1 | The pulse-count limit was exceeded |
| window_done | input | 1 | The erase-collect window has closed |
| suspended | input | 1 | The erase is suspended |
| erase_mask | input | N_SECT | Sectors selected for erase |
| reset_cmd | input | 1 | Reset command received |
| rd_stb | input | 1 | A read is occurring this cycle |
| rd_sector | input | SECT_W | Sector of the read address |
| status_q | output | 8 | Status byte |
| use_array | output | 1 | 1: the read path returns array data |

## Verification
On every cycle, the assertions check several things. Bit 5 is sticky. The toggle flop clears at a start and inverts on each qualifying strobe. The protect countdown moves by exactly one step per cycle. Bit 7 is forced high in a suspended sector, bit 3 stays low during programs, and the unused bits stay at zero. Other properties hold only across a whole sequence, and only the bench scenarios can show them: the exact length of the protected-program busy window, the choice between array and status per sector while suspended, and whether toggle polling and complement polling reach the right pass or fail verdict.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [1:0] {
    OPK_IDLE = 2'b00,
    OPK_PROG = 2'b01,
    OPK_CHIP = 2'b10,
    OPK_SECT = 2'b11
  } opk_e;
endpackage

// File: rtl/fs_op_track.sv
module fs_op_track
  import fs_pkg::*;
#(
  parameter int PROT_CYCLES = 400,
  parameter int CNT_W = $clog2(PROT_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_start,
  input  logic [1:0]       op_kind,
  input  logic             prog_bit7,
  input  logic             tgt_locked,
  input  logic             op_busy,
  output opk_e             kind_q,
  output logic             b7_q,
  output logic [CNT_W-1:0] pcnt_q,
  output logic             active
);
  localparam logic [CNT_W-1:0] PROT_LOAD = CNT_W'(PROT_CYCLES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= OPK_IDLE;
      b7_q   <= 1'b0;
      pcnt_q <= '0;
    end else if (op_start) begin
      kind_q <= opk_e'(op_kind);
      b7_q   <= prog_bit7;
      pcnt_q <= (opk_e'(op_kind) == OPK_PROG && tgt_locked) ? PROT_LOAD : '0;
    end else if (pcnt_q != '0) begin
      pcnt_q <= pcnt_q - 1'b1;
    end
  end

  assign active = op_busy || (pcnt_q != '0);
endmodule

// File: rtl/fs_flags.sv
module fs_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic op_start,
  input  logic rd_stb,
  input  logic status_mode,
  input  logic susp_eff,
  input  logic active,
  input  logic limit_hit,
  input  logic reset_cmd,
  output logic tog_q,
  output logic fail_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
    end else if (op_start) begin
      tog_q <= 1'b0;
    end else if (rd_stb && status_mode && !susp_eff) begin
      tog_q <= ~tog_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
    end else if (limit_hit && active) begin
      fail_q <= 1'b1;
    end else if (reset_cmd) begin
      fail_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fs_byte_mux.sv
module fs_byte_mux
  import fs_pkg::*;
#(
  parameter int N_SECT = 8,
  parameter int SECT_W = $clog2(N_SECT)
) (
  input  opk_e              kind_q,
  input  logic              b7_q,
  input  logic              tog_q,
  input  logic              fail_q,
  input  logic              window_done,
  input  logic              susp_eff,
  input  logic              status_mode,
  input  logic [N_SECT-1:0] erase_mask,
  input  logic [SECT_W-1:0] rd_sector,
  output logic [7:0]        status_q,
  output logic              use_array
);
  logic is_erase, dq7, dq3, in_masked;

  always_comb begin
    is_erase  = (kind_q == OPK_CHIP) || (kind_q == OPK_SECT);
    in_masked = erase_mask[rd_sector];
    if (susp_eff)                dq7 = 1'b1;
    else if (kind_q == OPK_PROG) dq7 = ~b7_q;
    else                         dq7 = 1'b0;
    dq3       = is_erase && window_done;
    status_q  = {dq7, tog_q, fail_q, 1'b0, dq3, 3'b000};
    use_array = !status_mode || (susp_eff && !in_masked);
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import fs_pkg::*;
#(
  parameter int N_SECT      = 8,
  parameter int PROT_CYCLES = 400,
  parameter int SECT_W      = $clog2(N_SECT),
  parameter int CNT_W       = $clog2(PROT_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic [1:0]        op_kind,
  input  logic              prog_bit7,
  input  logic              tgt_locked,
  input  logic              op_busy,
  input  logic              limit_hit,
  input  logic              window_done,
  input  logic              suspended,
  input  logic [N_SECT-1:0] erase_mask,
  input  logic              reset_cmd,
  input  logic              rd_stb,
  input  logic [SECT_W-1:0] rd_sector,
  output logic [7:0]        status_q,
  output logic              use_array
);
  opk_e             kind_q;
  logic             b7_q, active, tog_q, fail_q, status_mode, susp_eff;
  logic [CNT_W-1:0] pcnt_q;

  fs_op_track #(.PROT_CYCLES(PROT_CYCLES), .CNT_W(CNT_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
    .prog_bit7(prog_bit7), .tgt_locked(tgt_locked), .op_busy(op_busy),
    .kind_q(kind_q), .b7_q(b7_q), .pcnt_q(pcnt_q), .active(active)
  );

  assign status_mode = active || fail_q;
  assign susp_eff    = suspended && (kind_q == OPK_SECT);

  fs_flags u_flg (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .rd_stb(rd_stb),
    .status_mode(status_mode), .susp_eff(susp_eff), .active(active),
    .limit_hit(limit_hit), .reset_cmd(reset_cmd),
    .tog_q(tog_q), .fail_q(fail_q)
  );

  fs_byte_mux #(.N_SECT(N_SECT), .SECT_W(SECT_W)) u_mux (
    .kind_q(kind_q), .b7_q(b7_q), .tog_q(tog_q), .fail_q(fail_q),
    .window_done(window_done), .susp_eff(susp_eff), .status_mode(status_mode),
    .erase_mask(erase_mask), .rd_sector(rd_sector),
    .status_q(status_q), .use_array(use_array)
  );
endmodule

// File: rtl/fs_checker.sv
module fs_checker
  import fs_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_start,
  input logic             rd_stb,
  input logic             reset_cmd,
  input logic [7:0]       status_q,
  input opk_e             kind_q,
  input logic             tog_q,
  input logic [CNT_W-1:0] pcnt_q,
  input logic             status_mode,
  input logic             susp_eff
);
  p_fail_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[5] && !reset_cmd) |=> status_q[5]);

  p_start_clears_tog_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !tog_q);

  p_tog_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && status_mode && !susp_eff && !op_start) |=> (tog_q != $past(tog_q)));

  p_tog_hold_susp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_eff && !op_start) |=> $stable(tog_q));

  p_susp_dq7_r7: assert property (@(posedge clk) disable iff (!rst_n)
    susp_eff |-> status_q[7]);

  p_prog_dq3_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == OPK_PROG) |-> !status_q[3]);

  p_zero_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[4] == 1'b0) && (status_q[2:0] == 3'b000));

  p_prot_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pcnt_q != '0 && !op_start) |=> (pcnt_q == $past(pcnt_q) - 1'b1));
endmodule

bind flash_status_gen fs_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_start(op_start), .rd_stb(rd_stb),
  .reset_cmd(reset_cmd), .status_q(status_q), .kind_q(kind_q), .tog_q(tog_q),
  .pcnt_q(pcnt_q), .status_mode(status_mode), .susp_eff(susp_eff)
);

// File: tb/sim_flash_status_gen.sv
`timescale 1ns/1ps
module sim_flash_status_gen;
  localparam int N_SECT = 8;
  localparam int SECT_W = 3;
  localparam int PROT   = 400;

  logic clk = 0, rst_n = 0;
  logic op_start = 0, prog_bit7 = 0, tgt_locked = 0, op_busy = 0, limit_hit = 0;
  logic window_done = 0, suspended = 0, reset_cmd = 0, rd_stb = 0;
  logic [1:0] op_kind = 0;
  logic [N_SECT-1:0] erase_mask = 0;
  logic [SECT_W-1:0] rd_sector = 0;
  logic [7:0] status_q;
  logic use_array;
  logic [7:0] array_byte = 8'h00;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_status_gen #(.N_SECT(N_SECT), .PROT_CYCLES(PROT)) u0 (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
    .prog_bit7(prog_bit7), .tgt_locked(tgt_locked), .op_busy(op_busy),
    .limit_hit(limit_hit), .window_done(window_done), .suspended(suspended),
    .erase_mask(erase_mask), .reset_cmd(reset_cmd), .rd_stb(rd_stb),
    .rd_sector(rd_sector), .status_q(status_q), .use_array(use_array)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_kind = 0, m_b7 = 0, m_tog = 0, m_fail = 0, m_pcnt = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_kind = 0; m_b7 = 0; m_tog = 0; m_fail = 0; m_pcnt = 0;
    end else begin
      bit act, smode, susp;
      act   = op_busy || (m_pcnt != 0);
      smode = act || (m_fail != 0);
      susp  = suspended && (m_kind == 3);
      if (op_start) begin
        m_kind = op_kind; m_b7 = prog_bit7; m_tog = 0;
        m_pcnt = (op_kind == 2'b01 && tgt_locked) ? PROT : 0;
      end else begin
        if (rd_stb && smode && !susp) m_tog = 1 - m_tog;
        if (m_pcnt > 0) m_pcnt--;
      end
      if (limit_hit && act) m_fail = 1;
      else if (reset_cmd) m_fail = 0;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      bit act, smode, susp, ua;
      int e7, e3;
      act   = op_busy || (m_pcnt != 0);
      smode = act || (m_fail != 0);
      susp  = suspended && (m_kind == 3);
      ua    = !smode || (susp && !erase_mask[rd_sector]);
      check(use_array == ua, "R7 use_array", use_array, ua);
      if (!ua) begin
        e7 = susp ? 1 : (m_kind == 1 ? 1 - m_b7 : 0);
        e3 = (m_kind >= 2) ? int'(window_done) : 0;
        check(status_q[7] == e7[0], "R2 dq7", status_q[7], e7);
        check(status_q[6] == m_tog[0], "R4 dq6", status_q[6], m_tog);
        check(status_q[5] == m_fail[0], "R5 dq5", status_q[5], m_fail);
        check(status_q[3] == e3[0], "R6 dq3", status_q[3], e3);
      end
      check({status_q[4], status_q[2:0]} == 4'b0, "R9 spare bits", status_q, 0);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_op(input logic [1:0] k, input logic b7, input logic lock);
    @(negedge clk);
    op_kind = k; prog_bit7 = b7; tgt_locked = lock; op_start = 1;
    @(negedge clk);
    op_start = 0; tgt_locked = 0;
  endtask

  // one read: strobe held for one cycle, byte taken mid-cycle
  task automatic do_read(input logic [SECT_W-1:0] sec, output logic [7:0] d);
    @(negedge clk);
    rd_sector = sec; rd_stb = 1;
    #2;
    d = use_array ? array_byte : status_q;
    @(negedge clk);
    rd_stb = 0;
  endtask

  // 0 = done, 1 = failed, 2 = still busy
  task automatic toggle_poll(input logic [SECT_W-1:0] sec, output int res);
    logic [7:0] a, b;
    do_read(sec, a); do_read(sec, b);
    if (a[6] == b[6]) res = 0;
    else if (!b[5]) res = 2;
    else begin
      do_read(sec, a); do_read(sec, b);
      res = (a[6] == b[6]) ? 0 : 1;
    end
  endtask

  task automatic data_poll(input logic [SECT_W-1:0] sec, input logic want7, output int res);
    logic [7:0] d;
    do_read(sec, d);
    if (d[7] == want7) res = 0;
    else if (!d[5]) res = 2;
    else begin
      do_read(sec, d);
      res = (d[7] == want7) ? 0 : 1;
    end
  endtask

  initial begin
    int res, n;
    logic [7:0] d;
    tick(3);
    rst_n = 1;
    tick(1);
    #2;
    check(use_array == 1 && status_q[6] == 0 && status_q[5] == 0, "R1 reset state",
          {use_array, status_q}, 9'h100);

    // Normal program, bit7 = 1 -> DQ7 reads 0 while busy
    array_byte = 8'hA5;
    start_op(2'b01, 1'b1, 1'b0);
    op_busy = 1;
    data_poll(0, 1'b1, res);
    check(res == 2, "R2 data poll busy", res, 2);
    toggle_poll(5, res);
    check(res == 2, "R4 toggle busy", res, 2);
    @(negedge clk) op_busy = 0;
    data_poll(0, 1'b1, res);
    check(res == 0, "R2 data poll done", res, 0);
    toggle_poll(0, res);
    check(res == 0, "R9 toggle done", res, 0);

    // Chip erase: DQ7 = 0, DQ3 follows the window, suspend ignored
    array_byte = 8'hFF;
    start_op(2'b10, 1'b0, 1'b0);
    op_busy = 1;
    do_read(1, d);
    check(d[7] == 0 && d[3] == 0, "R3 erase dq7 before window", d, 8'h00);
    window_done = 1; suspended = 1;
    do_read(1, d);
    check(d[3] == 1, "R6 window", d[3], 1);
    toggle_poll(1, res);
    check(res == 2, "R7 chip erase ignores suspend", res, 2);
    suspended = 0;
    @(negedge clk) op_busy = 0; window_done = 0;
    data_poll(1, 1'b1, res);
    check(res == 0, "R3 erase done", res, 0);

    // Sector erase with suspend
    erase_mask = 8'b0010_0100;
    start_op(2'b11, 1'b0, 1'b0);
    op_busy = 1; window_done = 1;
    @(negedge clk) suspended = 1;
    array_byte = 8'h3C;
    do_read(3, d);
    check(d == 8'h3C, "R7 unmasked sector reads array", d, 8'h3C);
    toggle_poll(2, res);
    check(res == 0, "R7 suspended sector no toggle", res, 0);
    do_read(5, d);
    check(d[7] == 1, "R7 suspended dq7", d[7], 1);
    @(negedge clk) suspended = 0;
    toggle_poll(5, res);
    check(res == 2, "R4 resumed toggles", res, 2);
    @(negedge clk) op_busy = 0; window_done = 0; erase_mask = 0;

    // Program hits the pulse limit (0 -> 1 attempt)
    array_byte = 8'h00;
    start_op(2'b01, 1'b1, 1'b0);
    op_busy = 1;
    tick(2);
    limit_hit = 1;
    @(negedge clk) limit_hit = 0; op_busy = 0;
    tick(3);
    toggle_poll(0, res);
    check(res == 1, "R5 toggle poll fail", res, 1);
    data_poll(0, 1'b1, res);
    check(res == 1, "R5 data poll fail", res, 1);
    @(negedge clk) reset_cmd = 1;
    @(negedge clk) reset_cmd = 0;
    #2;
    check(use_array == 1, "R5 reset clears", use_array, 1);

    // Protected program target
    start_op(2'b01, 1'b0, 1'b1);
    n = 0;
    #2;
    while (!use_array && n < PROT + 10) begin
      n++;
      @(negedge clk); #2;
    end
    check(n == PROT, "R8 protect window length", n, PROT);

    tick(4);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule